// File: doc/BRIEF.md
# Egress Queue Scheduler with Strict Priority and Deficit Round Robin

This block decides which of the queues feeding one egress port is served next. Each queue has a small configuration entry. The entry gives the queue a priority class, a deficit-round-robin weight, a charging unit (bytes or whole packets) and a length-accounting mode. Classes are served in strict order: a lower class number always wins. Queues in the same class share the port through deficit round robin. A queue that is visited gains `weight × QUANTUM` credit. It is then served while its credit covers the cost of its head packet, and its credit is dropped as soon as it runs empty.

The upstream queue manager presents one backlog flag and the head-packet length for each queue. The scheduler presents its choice on a valid/ready stream. `sel_valid` rises with `sel_queue` and both are held unchanged while `sel_ready` is low. This is how back-pressure works: the consumer may stall for as long as it likes. A transfer happens on any clock edge where both are high, and it means that the head packet of that queue has been dequeued. Its cost is charged at that moment. No new choice is made until the transfer has happened. Every transfer is followed by at least one cycle with `sel_valid` low, in which the next choice is made.

A level-count register sets how many priority classes are in use. A count of zero merges every queue into class 0, which gives plain round robin. A configured priority at or above a non-zero count is folded into the last class in use.

Top module: `qs_top`

## Requirements
- R1: While `rst_n` is low, `sel_valid` is 0. Reset loads every queue with priority 0, weight 1, byte charging and length mode 1, and sets the level count to 8.
- R2: A choice is never made for a queue while a backlogged queue sits in a lower-numbered effective class. Classes are checked from 0 upwards.
- R3: Within one class, queues are served by deficit round robin. A visited queue gains `weight × QUANTUM` credit, and its credit is cleared while it is not backlogged. With equal 64-byte packets, a weight-2 queue is served twice for each service of a weight-1 queue.
- R4: When configuration bit 13 (packet unit) is 1, every packet costs 1, whatever its length.
- R5: In byte charging, length mode 0 (`wdata[15:14]=0`) charges the head length plus 20. Mode 1, and the unused code 3, charge the head length as it is.
- R6: Length mode 2 charges the head length minus 18, and charges 0 when the length is 18 or less.
- R7: A level count of 0 (`cfg_lvl_wdata`) puts every queue in class 0, so configured priorities have no effect.
- R8: With a level count N from 1 to 7, a configured priority p ≥ N is treated as class N−1.
- R9: A configuration write with weight 0 stores weight 1.
- R10: While `sel_valid` is high and `sel_ready` is low, `sel_valid` stays high and `sel_queue` stays unchanged. After a transfer, `sel_valid` is low for at least one cycle.
- R11: The queue named when `sel_valid` rises is backlogged. Table writes use `wdata[2:0]` for priority, `wdata[12:3]` for weight, bit 13 for the unit and `wdata[15:14]` for the length mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_backlog | input | NQ | Per-queue backlog flag |
| q_head_len | input | NQ*LW | Head-packet length in bytes, queue i at bits [i*LW +: LW] |
| cfg_tbl_we | input | 1 | Write strobe for one queue entry |
| cfg_tbl_addr | input | log2(NQ) | Queue index to write |
| cfg_tbl_wdata | input | 16 | Queue entry: prio[2:0], weight[12:3], unit[13], mode[15:14] |
| cfg_lvl_we | input | 1 | Write strobe for the level count |
| cfg_lvl_wdata | input | 4 | Number of priority classes in use (0 = flat) |
| sel_valid | output | 1 | A choice is on offer |
| sel_ready | input | 1 | Consumer has dequeued the offered head packet |
| sel_queue | output | log2(NQ) | Chosen queue index |

## Verification
The orderings that are hardest to reach are the ones where a queue's credit falls just short of its head cost. Only then does the visiting order show whether the length compensation, the packet unit, the weight and the emptied-queue clear are right. The stimulus table therefore picks head lengths that put the compensated cost exactly on a quantum boundary, such as 44+20 and 82−18 against a quantum of 64, or just above it. Each wrong charge then reorders the expected sequence of served queues. The tests for saturation below zero and for weight 0 are built so that a faulty design stalls or changes the order at once, rather than drifting.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int PRIO_W   = 3;
  localparam int NLVL     = 8;
  localparam int WGT_W    = 10;
  localparam int LVL_W    = 4;
  localparam int WIRE_OVH = 20;  // gap + preamble bytes added in mode 0
  localparam int L3_STRIP = 18;  // header + CRC bytes removed in mode 2

  typedef enum logic [1:0] {
    LM_WIRE  = 2'd0,
    LM_FRAME = 2'd1,
    LM_L3    = 2'd2
  } len_mode_e;

  typedef struct packed {
    logic [1:0]        mode;
    logic              pkt_unit;
    logic [WGT_W-1:0]  weight;
    logic [PRIO_W-1:0] prio;
  } qcfg_t;
endpackage

// File: rtl/qs_cfg.sv
module qs_cfg
  import qs_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tbl_we,
  input  logic [QW-1:0]                 tbl_addr,
  input  logic [15:0]                   tbl_wdata,
  input  logic                          lvl_we,
  input  logic [LVL_W-1:0]              lvl_wdata,
  output qcfg_t [NQ-1:0]                cfg,
  output logic  [NQ-1:0][PRIO_W-1:0]    eff_prio
);
  qcfg_t            wr_entry;
  logic [LVL_W-1:0] levels;

  always_comb begin
    wr_entry = qcfg_t'(tbl_wdata);
    if (wr_entry.weight == '0) wr_entry.weight = WGT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) begin
        cfg[i] <= '{mode: LM_FRAME, pkt_unit: 1'b0, weight: WGT_W'(1), prio: '0};
      end
      levels <= LVL_W'(NLVL);
    end else begin
      if (tbl_we && (int'(tbl_addr) < NQ)) cfg[tbl_addr] <= wr_entry;
      if (lvl_we) levels <= lvl_wdata;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_eff
    always_comb begin
      if (levels == '0)
        eff_prio[g] = '0;
      else if ({1'b0, cfg[g].prio} >= levels)
        eff_prio[g] = PRIO_W'(levels - LVL_W'(1));
      else
        eff_prio[g] = cfg[g].prio;
    end
  end
endmodule

// File: rtl/qs_cost.sv
module qs_cost
  import qs_pkg::*;
#(
  parameter int NQ = 8,
  parameter int LW = 14,
  parameter int CW = LW + 1
) (
  input  logic  [NQ*LW-1:0]         head_len,
  input  qcfg_t [NQ-1:0]            cfg,
  output logic  [NQ-1:0][CW-1:0]    cost
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [LW-1:0] len;
    assign len = head_len[g*LW +: LW];

    always_comb begin
      if (cfg[g].pkt_unit) begin
        cost[g] = CW'(1);
      end else begin
        case (cfg[g].mode)
          LM_WIRE: cost[g] = CW'(len) + CW'(WIRE_OVH);
          LM_L3:   cost[g] = (len > LW'(L3_STRIP)) ? CW'(len - LW'(L3_STRIP)) : '0;
          default: cost[g] = CW'(len);
        endcase
      end
    end
  end
endmodule

// File: rtl/qs_pick.sv
module qs_pick
  import qs_pkg::*;
#(
  parameter int NQ      = 8,
  parameter int QW      = 3,
  parameter int CW      = 15,
  parameter int DW      = 18,
  parameter int QUANTUM = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic  [NQ-1:0]             q_backlog,
  input  logic  [NQ-1:0][PRIO_W-1:0] eff_prio,
  input  qcfg_t [NQ-1:0]             cfg,
  input  logic  [NQ-1:0][CW-1:0]     cost,
  input  logic                       sel_ready,
  output logic                       sel_valid,
  output logic  [QW-1:0]             sel_queue
);
  logic [NLVL-1:0]      any_at;
  logic                 any_bl;
  logic [PRIO_W-1:0]    top_p;
  logic [QW-1:0]        cur     [NLVL];
  logic [DW-1:0]        deficit [NQ];
  logic [QW-1:0]        cur_q, nxt;
  logic                 ok, serving;
  logic [QW-1:0]        sel_q;
  logic [CW-1:0]        sel_cost;
  logic [DW-1:0]        grant;

  always_comb begin
    for (int p = 0; p < NLVL; p++) begin
      any_at[p] = 1'b0;
      for (int i = 0; i < NQ; i++)
        if (q_backlog[i] && (int'(eff_prio[i]) == p)) any_at[p] = 1'b1;
    end
    any_bl = |q_backlog;
    top_p  = '0;
    for (int p = NLVL - 1; p >= 0; p--)
      if (any_at[p]) top_p = PRIO_W'(p);
  end

  assign cur_q = cur[top_p];
  assign ok    = q_backlog[cur_q] && (eff_prio[cur_q] == top_p) &&
                 (deficit[cur_q] >= DW'(cost[cur_q]));

  always_comb begin
    nxt = cur_q;
    for (int k = NQ; k >= 1; k--) begin
      int t;
      t = int'(cur_q) + k;
      if (t >= NQ) t = t - NQ;
      if (q_backlog[t] && (eff_prio[t] == top_p)) nxt = QW'(t);
    end
  end

  assign grant = DW'(cfg[nxt].weight) * DW'(QUANTUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serving  <= 1'b0;
      sel_q    <= '0;
      sel_cost <= '0;
      for (int p = 0; p < NLVL; p++) cur[p] <= '0;
    end else if (serving) begin
      if (sel_ready) serving <= 1'b0;
    end else if (any_bl) begin
      if (ok) begin
        serving  <= 1'b1;
        sel_q    <= cur_q;
        sel_cost <= cost[cur_q];
      end else begin
        cur[top_p] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NQ; i++) deficit[i] <= '0;
    end else begin
      for (int i = 0; i < NQ; i++) begin
        if (serving && sel_ready && (sel_q == QW'(i)))
          deficit[i] <= deficit[i] - DW'(sel_cost);
        else if (!serving && any_bl && !ok && (nxt == QW'(i)))
          deficit[i] <= deficit[i] + grant;
        else if (!q_backlog[i] && !(serving && (sel_q == QW'(i))))
          deficit[i] <= '0;
      end
    end
  end

  assign sel_valid = serving;
  assign sel_queue = sel_q;
endmodule

// File: rtl/qs_top.sv
module qs_top
  import qs_pkg::*;
#(
  parameter int NQ      = 8,
  parameter int LW      = 14,
  parameter int QUANTUM = 64,
  localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    q_backlog,
  input  logic [NQ*LW-1:0] q_head_len,
  input  logic             cfg_tbl_we,
  input  logic [QW-1:0]    cfg_tbl_addr,
  input  logic [15:0]      cfg_tbl_wdata,
  input  logic             cfg_lvl_we,
  input  logic [3:0]       cfg_lvl_wdata,
  output logic             sel_valid,
  input  logic             sel_ready,
  output logic [QW-1:0]    sel_queue
);
  localparam int CW = LW + 1;
  localparam int GW = WGT_W + $clog2(QUANTUM + 1);
  localparam int DW = ((CW > GW) ? CW : GW) + 1;

  qcfg_t [NQ-1:0]             cfg_w;
  logic  [NQ-1:0][PRIO_W-1:0] eff_prio;
  logic  [NQ-1:0][CW-1:0]     cost;

  qs_cfg #(.NQ(NQ), .QW(QW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(cfg_tbl_we), .tbl_addr(cfg_tbl_addr), .tbl_wdata(cfg_tbl_wdata),
    .lvl_we(cfg_lvl_we), .lvl_wdata(cfg_lvl_wdata),
    .cfg(cfg_w), .eff_prio(eff_prio)
  );

  qs_cost #(.NQ(NQ), .LW(LW), .CW(CW)) u_cost (
    .head_len(q_head_len), .cfg(cfg_w), .cost(cost)
  );

  qs_pick #(.NQ(NQ), .QW(QW), .CW(CW), .DW(DW), .QUANTUM(QUANTUM)) u_pick (
    .clk(clk), .rst_n(rst_n), .q_backlog(q_backlog), .eff_prio(eff_prio),
    .cfg(cfg_w), .cost(cost), .sel_ready(sel_ready),
    .sel_valid(sel_valid), .sel_queue(sel_queue)
  );
endmodule

// File: rtl/qs_chk.sv
module qs_chk
  import qs_pkg::*;
#(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NQ-1:0]              q_backlog,
  input logic                       sel_valid,
  input logic                       sel_ready,
  input logic [QW-1:0]              sel_queue,
  input logic [NQ-1:0][PRIO_W-1:0]  eff_prio,
  input qcfg_t [NQ-1:0]             cfg
);
  logic hi_waiting;
  logic zero_wt;

  always_comb begin
    hi_waiting = 1'b0;
    zero_wt    = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (q_backlog[i] && (eff_prio[i] < eff_prio[sel_queue])) hi_waiting = 1'b1;
      if (cfg[i].weight == '0) zero_wt = 1'b1;
    end
  end

  always_comb begin
    if (!rst_n) a_r1_idle_in_reset: assert (!sel_valid);
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable(sel_queue)));

  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_ready) |=> !sel_valid);

  a_r2_strict: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid) |-> !hi_waiting);

  a_r11_backlogged: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid) |-> q_backlog[sel_queue]);

  a_r9_no_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_wt);
endmodule

bind qs_top qs_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_backlog(q_backlog), .sel_valid(sel_valid),
  .sel_ready(sel_ready), .sel_queue(sel_queue), .eff_prio(eff_prio), .cfg(cfg_w)
);

// File: tb/tb_qs_top.sv
module tb_qs_top;
  localparam int NQ = 8;
  localparam int LW = 14;
  localparam int QW = 3;
  localparam int NV = 9;

  typedef struct packed {
    logic [2:0]  idx;
    logic [2:0]  pri;
    logic [9:0]  wt;
    logic        unit;
    logic [1:0]  mode;
    logic [13:0] len;
    logic [3:0]  cnt;
  } qv_t;

  typedef struct packed {
    logic [3:0]        lvl;
    qv_t [2:0]         q;
    logic [11:0][3:0]  exp;  // exp[11] is served first, 4'hF ends the list
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R2 strict classes
    '{4'd8, '{qv_t'{3'd2,3'd0,10'd1,1'b1,2'd1,14'd64,4'd2},
              qv_t'{3'd5,3'd1,10'd1,1'b1,2'd1,14'd64,4'd2},
              qv_t'{3'd7,3'd2,10'd1,1'b1,2'd1,14'd64,4'd1}}, 48'h22557FFFFFFF},
    // R3 weights 1 and 2
    '{4'd8, '{qv_t'{3'd1,3'd0,10'd1,1'b0,2'd1,14'd64,4'd3},
              qv_t'{3'd3,3'd0,10'd2,1'b0,2'd1,14'd64,4'd3},
              qv_t'{3'd4,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h133131FFFFFF},
    // R5 mode 0 adds 20
    '{4'd8, '{qv_t'{3'd0,3'd0,10'd1,1'b0,2'd0,14'd44,4'd2},
              qv_t'{3'd1,3'd0,10'd1,1'b0,2'd1,14'd44,4'd3},
              qv_t'{3'd6,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h10101FFFFFFF},
    // R6 mode 2 subtracts 18
    '{4'd8, '{qv_t'{3'd2,3'd0,10'd1,1'b0,2'd2,14'd82,4'd2},
              qv_t'{3'd3,3'd0,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd6,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h2323FFFFFFFF},
    // R6 saturation at zero
    '{4'd8, '{qv_t'{3'd0,3'd0,10'd1,1'b0,2'd2,14'd10,4'd3},
              qv_t'{3'd1,3'd0,10'd1,1'b0,2'd1,14'd64,4'd1},
              qv_t'{3'd6,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h0001FFFFFFFF},
    // R7 flat when level count is 0
    '{4'd0, '{qv_t'{3'd4,3'd3,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd6,3'd0,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd7,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h4646FFFFFFFF},
    // R8 fold into last class
    '{4'd2, '{qv_t'{3'd1,3'd5,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd2,3'd1,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd0,3'd0,10'd1,1'b0,2'd1,14'd64,4'd1}}, 48'h01212FFFFFFF},
    // R4 packet unit
    '{4'd8, '{qv_t'{3'd3,3'd0,10'd1,1'b1,2'd1,14'd1000,4'd2},
              qv_t'{3'd5,3'd0,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd7,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h3355FFFFFFFF},
    // R9 weight 0 stored as 1
    '{4'd8, '{qv_t'{3'd1,3'd0,10'd0,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd2,3'd0,10'd1,1'b0,2'd1,14'd64,4'd2},
              qv_t'{3'd7,3'd7,10'd1,1'b0,2'd1,14'd64,4'd0}}, 48'h1212FFFFFFFF}
  };
  localparam int VREQ [NV] = '{2, 3, 5, 6, 6, 7, 8, 4, 9};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NQ-1:0]    q_backlog = '0;
  logic [NQ*LW-1:0] q_head_len = '0;
  logic             cfg_tbl_we = 1'b0;
  logic [QW-1:0]    cfg_tbl_addr = '0;
  logic [15:0]      cfg_tbl_wdata = '0;
  logic             cfg_lvl_we = 1'b0;
  logic [3:0]       cfg_lvl_wdata = '0;
  logic             sel_valid;
  logic             sel_ready = 1'b0;
  logic [QW-1:0]    sel_queue;

  int checks = 0;
  int fails  = 0;
  int cnt [NQ];

  always #10 clk = ~clk;

  qs_top #(.NQ(NQ), .LW(LW), .QUANTUM(64)) dut (
    .clk(clk), .rst_n(rst_n), .q_backlog(q_backlog), .q_head_len(q_head_len),
    .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_addr(cfg_tbl_addr), .cfg_tbl_wdata(cfg_tbl_wdata),
    .cfg_lvl_we(cfg_lvl_we), .cfg_lvl_wdata(cfg_lvl_wdata),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_queue(sel_queue)
  );

  task automatic check(input int req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL R%0d: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; q_backlog = '0; sel_ready = 1'b0;
    for (int i = 0; i < NQ; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_q(input int q, input logic [2:0] pri, input logic [9:0] wt,
                      input logic unit, input logic [1:0] mode);
    cfg_tbl_we = 1'b1; cfg_tbl_addr = QW'(q); cfg_tbl_wdata = {mode, unit, wt, pri};
    @(negedge clk);
    cfg_tbl_we = 1'b0;
  endtask

  task automatic wr_lvl(input logic [3:0] n);
    cfg_lvl_we = 1'b1; cfg_lvl_wdata = n;
    @(negedge clk);
    cfg_lvl_we = 1'b0;
  endtask

  task automatic refresh();
    for (int i = 0; i < NQ; i++) q_backlog[i] = (cnt[i] > 0);
  endtask

  task automatic wait_sel(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (sel_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic take(input int q);
    sel_ready = 1'b1;
    @(negedge clk);
    sel_ready = 1'b0;
    if (cnt[q] > 0) cnt[q]--;
    refresh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    int q;
    // R1: held reset with traffic pending keeps sel_valid low
    rst_n = 1'b0;
    q_backlog = '1;
    repeat (4) @(negedge clk);
    check(1, int'(sel_valid), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr_lvl(VECS[v].lvl);
      for (int i = 0; i < NQ; i++) wr_q(i, 3'd7, 10'd1, 1'b0, 2'd1);
      for (int e = 0; e < 3; e++) begin
        wr_q(int'(VECS[v].q[e].idx), VECS[v].q[e].pri, VECS[v].q[e].wt,
             VECS[v].q[e].unit, VECS[v].q[e].mode);
        cnt[VECS[v].q[e].idx] = int'(VECS[v].q[e].cnt);
        q_head_len[int'(VECS[v].q[e].idx)*LW +: LW] = VECS[v].q[e].len;
      end
      refresh();
      for (int k = 11; k >= 0; k--) begin
        if (VECS[v].exp[k] == 4'hF) break;
        wait_sel(seen);
        if (!seen) begin
          check(VREQ[v], 15, int'(VECS[v].exp[k]));
          break;
        end
        q = int'(sel_queue);
        check(VREQ[v], q, int'(VECS[v].exp[k]));
        take(q);
      end
      repeat (20) @(negedge clk);
      check(VREQ[v], int'(sel_valid), 0);
    end

    // R10: back-pressure holds the offer, transfer drops it for a cycle
    do_reset();
    cnt[3] = 2;
    q_head_len[3*LW +: LW] = 14'd64;
    refresh();
    wait_sel(seen);
    check(10, int'(seen), 1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(10, int'(sel_valid), 1);
      check(10, int'(sel_queue), 3);
    end
    take(3);
    check(10, int'(sel_valid), 0);
    wait_sel(seen);
    check(11, int'(sel_queue), 3);  // R11: offered queue is the backlogged one
    take(3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule